// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

The block keeps a 16-bit counter that runs freely at a selectable fraction of the CPU clock and compares it against two independent 16-bit compare values. When the counter steps onto a channel's compare value, the channel raises its match flag. If the channel's output is enabled, it also loads its programmed level onto its output pin. A single interrupt enable turns either raised flag into an interrupt request. Software can also force a channel's programmed level onto its pin at once. Such a forced update raises no flag and requests no interrupt.

A CPU reaches the block through an 8-bit register bus with synchronous write and read strobes. `bus_rdata` always shows the register at `bus_addr`. The read strobe exists only for its side effect on flag clearing. A 16-bit compare value is written as two bytes. Writing the upper byte stops that channel from matching, and matching resumes only once the lower byte has been written. Two mode inputs report that an external one-pulse or PWM generator owns the pins. While either is high, the software force path does nothing.

Register map, by `bus_addr`:

- 0 (control A): bit 7 is the interrupt enable, bit 1 is the level for channel 2, and bit 0 is the level for channel 1.
- 1 (control B): bit 7 is the output enable for channel 2 and bit 6 the output enable for channel 1. Bits 3:2 are the rate. Bits 1 and 0 are the force strobes for channels 2 and 1.
- 2 (status): bit 7 is the channel 1 flag and bit 6 the channel 2 flag.
- 3 and 4: compare value of channel 1, upper byte then lower byte.
- 5 and 6: compare value of channel 2, upper byte then lower byte.
- 7: unused.

Top module: `oc_timer_dual`

## Requirements
- R1: After reset, every register address reads 0x00, both compare values are 0, both channels are inhibited, `pin_level` and `pin_drive` are 0 and `irq` is 0.
- R2: The counter advances by one every 1, 2, 4 or 8 clocks for rate codes 0, 1, 2 and 3, and wraps from 0xFFFF to 0x0000. Compare values C and C+1 therefore flag exactly 1, 2, 4 or 8 clocks apart.
- R3: A write to a channel's upper compare byte (address 3 or 5) stops that channel from matching. It stays stopped until its lower byte (address 4 or 6) is written. A channel is also stopped from reset until its first lower-byte write.
- R4: When the counter steps onto an armed channel's compare value, the channel's status flag (bit 7 for channel 1, bit 6 for channel 2) is set in that same clock. If the output enable is set, `pin_level` takes the channel's level bit in that same clock.
- R5: With a channel's output enable clear, `pin_drive` for that channel is 0 and a match leaves `pin_level` unchanged. The match still sets the flag.
- R6: `irq` is high exactly when the interrupt enable (control A bit 7) is set and at least one flag is set.
- R7: Writing 1 to a channel's force bit (control B bit 0 or 1), with the output enable set in the same write, copies that channel's level bit to `pin_level` on the next clock. It sets no flag and leaves `irq` unchanged. The force bits always read 0.
- R8: While `opm_active` or `pwm_active` is high, force writes leave `pin_level` unchanged.
- R9: A flag clears only after two accesses in order: a strobed read of the status register while the flag is set, then a read or write of that channel's lower compare byte. A match in the same clock as the clearing access keeps the flag set.
- R10: Status bits 5:0 and address 7 read as 0, and control B bits 5:4 read as 0.
- R11: The two channels match, flag and drive their pins independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_rd | input | 1 | Read strobe, used only for flag clearing |
| bus_rdata | output | 8 | Content of the register at `bus_addr` |
| opm_active | input | 1 | One-pulse mode is active |
| pwm_active | input | 1 | PWM mode is active |
| pin_level | output | 2 | Latched output levels, bit 0 for channel 1 |
| pin_drive | output | 2 | Output enables, bit 0 for channel 1 |
| irq | output | 1 | Shared compare interrupt request |

## Verification
The hardest situations to reach are those that depend on exactly where the free-running counter stands when the CPU writes. One case is the window between an upper-byte and a lower-byte write, while the counter passes the half-written value. Another is the measured spacing of two matches at each rate. The stimulus cannot read the counter, so it follows a behavioural model of the counter that runs beside the design and places each compare value a fixed distance ahead of the model's count. It then waits on the status register without a read strobe. To cover wrap-around, the stimulus lets the counter run once through its full range at the fastest rate.

// File: rtl/oc_pkg.sv
package oc_pkg;

    localparam int NUM_CH = 2;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_CTLA = 3'd0,
        A_CTLB = 3'd1,
        A_STAT = 3'd2,
        A_C1HI = 3'd3,
        A_C1LO = 3'd4,
        A_C2HI = 3'd5,
        A_C2LO = 3'd6,
        A_NONE = 3'd7
    } reg_addr_e;

    // field positions inside the control registers
    localparam int CTLA_IEN  = 7;
    localparam int CTLB_OE0  = 6;
    localparam int CTLB_RATE = 2;

    typedef struct packed {
        logic              ien;
        logic [NUM_CH-1:0] lvl;
        logic [NUM_CH-1:0] oe;
        logic [1:0]        rate;
        logic [NUM_CH-1:0] flg;
        logic [NUM_CH-1:0] clr_arm;
        logic [NUM_CH-1:0] pin;
    } ctl_state_t;

endpackage

// File: rtl/oc_free_counter.sv
module oc_free_counter #(
    parameter int CNT_W = 16,
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       rate,
    output logic             tick,
    output logic [CNT_W-1:0] cnt_nxt
);

    typedef struct packed {
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [PRE_W-1:0] lim;

    always_comb begin
        lim     = PRE_W'((32'd1 << rate) - 32'd1);
        tick    = (s_q.pre >= lim);
        cnt_nxt = s_q.cnt + CNT_W'(1);
        s_d     = s_q;
        if (tick) begin
            s_d.pre = '0;
            s_d.cnt = cnt_nxt;
        end else begin
            s_d.pre = s_q.pre + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/oc_compare_chan.sv
module oc_compare_chan #(
    parameter int CNT_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              tick,
    input  logic [CNT_W-1:0]  cnt_nxt,
    output logic [CNT_W-1:0]  cmp,
    output logic              armed,
    output logic              hit
);

    typedef struct packed {
        logic [CNT_W-1:0] cmp;
        logic             armed;
    } chan_state_t;

    chan_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (wr_hi) begin
            s_d.cmp[CNT_W-1 -: BYTE_W] = wdata;
            s_d.armed                  = 1'b0;
        end
        if (wr_lo) begin
            s_d.cmp[BYTE_W-1:0] = wdata;
            s_d.armed           = 1'b1;
        end
        hit   = tick && s_q.armed && (cnt_nxt == s_q.cmp);
        cmp   = s_q.cmp;
        armed = s_q.armed;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/oc_timer_dual.sv
module oc_timer_dual
    import oc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int PRE_W = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    input  logic        bus_wr,
    input  logic        bus_rd,
    output logic [7:0]  bus_rdata,
    input  logic        opm_active,
    input  logic        pwm_active,
    output logic [1:0]  pin_level,
    output logic [1:0]  pin_drive,
    output logic        irq
);

    ctl_state_t        s_d, s_q;
    logic              tick;
    logic [CNT_W-1:0]  cnt_nxt;
    logic [CNT_W-1:0]  cmp_val [NUM_CH];
    logic [NUM_CH-1:0] hit, armed, wr_hi, wr_lo, lo_access, force_go;
    logic [NUM_CH-1:0] flag_vec;
    logic              ien_w;

    oc_free_counter #(.CNT_W(CNT_W), .PRE_W(PRE_W)) i_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate    (s_q.rate),
        .tick    (tick),
        .cnt_nxt (cnt_nxt)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [ADDR_W-1:0] HI_A = ADDR_W'(int'(A_C1HI) + 2*c);
        localparam logic [ADDR_W-1:0] LO_A = ADDR_W'(int'(A_C1LO) + 2*c);

        assign wr_hi[c]     = bus_wr && (bus_addr == HI_A);
        assign wr_lo[c]     = bus_wr && (bus_addr == LO_A);
        assign lo_access[c] = (bus_wr || bus_rd) && (bus_addr == LO_A);

        oc_compare_chan #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) i_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_hi   (wr_hi[c]),
            .wr_lo   (wr_lo[c]),
            .wdata   (bus_wdata),
            .tick    (tick),
            .cnt_nxt (cnt_nxt),
            .cmp     (cmp_val[c]),
            .armed   (armed[c]),
            .hit     (hit[c])
        );
    end

    always_comb begin
        logic ctla_wr, ctlb_wr, stat_rd, clr;
        ctla_wr = bus_wr && (bus_addr == A_CTLA);
        ctlb_wr = bus_wr && (bus_addr == A_CTLB);
        stat_rd = bus_rd && (bus_addr == A_STAT);
        s_d     = s_q;

        if (ctla_wr) begin
            s_d.ien = bus_wdata[CTLA_IEN];
            s_d.lvl = bus_wdata[NUM_CH-1:0];
        end
        if (ctlb_wr) begin
            s_d.oe   = bus_wdata[CTLB_OE0 +: NUM_CH];
            s_d.rate = bus_wdata[CTLB_RATE +: 2];
        end

        for (int c = 0; c < NUM_CH; c++) begin
            force_go[c] = ctlb_wr && bus_wdata[c] && bus_wdata[CTLB_OE0 + c]
                          && !(opm_active || pwm_active);
            clr = lo_access[c] && s_q.clr_arm[c];

            if (stat_rd && s_q.flg[c]) s_d.clr_arm[c] = 1'b1;
            else if (clr)              s_d.clr_arm[c] = 1'b0;

            if (hit[c])   s_d.flg[c] = 1'b1;
            else if (clr) s_d.flg[c] = 1'b0;

            if (hit[c] && s_q.oe[c]) s_d.pin[c] = s_q.lvl[c];
            else if (force_go[c])    s_d.pin[c] = s_q.lvl[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        case (bus_addr)
            A_CTLA:  bus_rdata = {s_q.ien, 5'b0, s_q.lvl};
            A_CTLB:  bus_rdata = {s_q.oe, 2'b0, s_q.rate, 2'b0};
            A_STAT:  bus_rdata = {s_q.flg[0], s_q.flg[1], 6'b0};
            A_C1HI:  bus_rdata = cmp_val[0][CNT_W-1 -: BYTE_W];
            A_C1LO:  bus_rdata = cmp_val[0][BYTE_W-1:0];
            A_C2HI:  bus_rdata = cmp_val[1][CNT_W-1 -: BYTE_W];
            A_C2LO:  bus_rdata = cmp_val[1][BYTE_W-1:0];
            default: bus_rdata = 8'h00;
        endcase
    end

    assign flag_vec  = s_q.flg;
    assign ien_w     = s_q.ien;
    assign pin_level = s_q.pin;
    assign pin_drive = s_q.oe;
    assign irq       = s_q.ien && (|s_q.flg);

endmodule

// File: rtl/oc_timer_dual_chk.sv
module oc_timer_dual_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] bus_addr,
    input logic       bus_wr,
    input logic [7:0] bus_rdata,
    input logic       opm_active,
    input logic       pwm_active,
    input logic [1:0] hit,
    input logic [1:0] force_go,
    input logic [1:0] armed,
    input logic [1:0] flg,
    input logic [1:0] pin,
    input logic       irq
);

    for (genvar c = 0; c < 2; c++) begin : g_chk
        localparam logic [2:0] HI_A = 3'(3 + 2*c);
        localparam logic [2:0] LO_A = 3'(4 + 2*c);

        AST_FLAG_FROM_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            (flg[c] && !$past(flg[c])) |-> $past(hit[c])); // R4
        AST_PIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (!$past(hit[c]) && !$past(force_go[c])) |-> $stable(pin[c])); // R7
        AST_HI_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == HI_A) |=> !armed[c]); // R3
        AST_LO_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
            (bus_wr && bus_addr == LO_A) |=> armed[c]); // R3
        AST_MODE_HOLDS_PIN: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(opm_active || pwm_active) && !$past(hit[c])) |-> $stable(pin[c])); // R8
    end

    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(|hit) || ($past(bus_wr) && $past(bus_addr) == 3'd0))); // R6
    AST_FORCE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd1) |-> (bus_rdata[1:0] == 2'b00)); // R7
    AST_STAT_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 3'd2) |-> (bus_rdata[5:0] == 6'b0)); // R10

endmodule

bind oc_timer_dual oc_timer_dual_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .opm_active (opm_active),
    .pwm_active (pwm_active),
    .hit        (hit),
    .force_go   (force_go),
    .armed      (armed),
    .flg        (flag_vec),
    .pin        (pin_level),
    .irq        (irq)
);

// File: tb/test_oc_timer_dual.sv
`timescale 1ns/1ps
module test_oc_timer_dual;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic       opm_active = 1'b0;
    logic       pwm_active = 1'b0;
    logic [7:0] bus_rdata;
    logic [1:0] pin_level, pin_drive;
    logic       irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    oc_timer_dual i_oc_timer_dual (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .opm_active(opm_active), .pwm_active(pwm_active),
        .pin_level(pin_level), .pin_drive(pin_drive), .irq(irq)
    );

    // behavioural reference model
    int     m_cnt = 0, m_pre = 0, m_rate = 0;
    int     m_cmp[2] = '{0, 0};
    bit     m_arm[2], m_flg[2], m_clr[2], m_pin[2], m_oe[2], m_lvl[2];
    bit     m_ien;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_pre = 0; m_rate = 0; m_ien = 0;
            for (int c = 0; c < 2; c++) begin
                m_cmp[c] = 0; m_arm[c] = 0; m_flg[c] = 0;
                m_clr[c] = 0; m_pin[c] = 0; m_oe[c] = 0; m_lvl[c] = 0;
            end
        end else begin
            bit tick;
            int nc;
            bit h[2];
            bit nf[2], ncl[2], np[2];
            tick = (m_pre >= (1 << m_rate) - 1);
            nc   = tick ? (m_cnt + 1) % 65536 : m_cnt;
            m_pre = tick ? 0 : m_pre + 1;
            for (int c = 0; c < 2; c++) begin
                bit clr, frc;
                h[c] = tick && m_arm[c] && (nc == m_cmp[c]);
                clr  = (bus_wr || bus_rd) && (int'(bus_addr) == 4 + 2*c) && m_clr[c];
                frc  = bus_wr && bus_addr == 3'd1 && bus_wdata[c] && bus_wdata[6+c]
                       && !(opm_active || pwm_active);
                nf[c]  = h[c] ? 1'b1 : (clr ? 1'b0 : m_flg[c]);
                ncl[c] = (bus_rd && bus_addr == 3'd2 && m_flg[c]) ? 1'b1 :
                         (clr ? 1'b0 : m_clr[c]);
                np[c]  = ((h[c] && m_oe[c]) || frc) ? m_lvl[c] : m_pin[c];
            end
            for (int c = 0; c < 2; c++) begin
                m_flg[c] = nf[c]; m_clr[c] = ncl[c]; m_pin[c] = np[c];
                if (bus_wr && int'(bus_addr) == 3 + 2*c) begin
                    m_cmp[c] = (m_cmp[c] % 256) + 256 * int'(bus_wdata);
                    m_arm[c] = 0;
                end
                if (bus_wr && int'(bus_addr) == 4 + 2*c) begin
                    m_cmp[c] = (m_cmp[c] / 256) * 256 + int'(bus_wdata);
                    m_arm[c] = 1;
                end
            end
            if (bus_wr && bus_addr == 3'd0) begin
                m_ien = bus_wdata[7]; m_lvl[0] = bus_wdata[0]; m_lvl[1] = bus_wdata[1];
            end
            if (bus_wr && bus_addr == 3'd1) begin
                m_oe[0] = bus_wdata[6]; m_oe[1] = bus_wdata[7];
                m_rate = int'(bus_wdata[3:2]);
            end
            m_cnt = nc;
        end
    end

    function automatic logic [7:0] m_rdata(input logic [2:0] a);
        case (a)
            3'd0: return {m_ien, 5'b0, m_lvl[1], m_lvl[0]};
            3'd1: return {m_oe[1], m_oe[0], 2'b0, 2'(m_rate), 2'b0};
            3'd2: return {m_flg[0], m_flg[1], 6'b0};
            3'd3: return 8'(m_cmp[0] / 256);
            3'd4: return 8'(m_cmp[0] % 256);
            3'd5: return 8'(m_cmp[1] / 256);
            3'd6: return 8'(m_cmp[1] % 256);
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s act=0x%0h exp=0x%0h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R4", "pin_level", int'(pin_level), int'({m_pin[1], m_pin[0]}));
            chk("R5", "pin_drive", int'(pin_drive), int'({m_oe[1], m_oe[0]}));
            chk("R6", "irq", int'(irq), int'(m_ien && (m_flg[0] || m_flg[1])));
            chk("R10", "rdata", int'(bus_rdata), int'(m_rdata(bus_addr)));
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_strobe(input logic [2:0] a);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic prog_cmp(input int ch, input int v);
        wr_reg(3'(3 + 2*ch), 8'(v / 256));
        wr_reg(3'(4 + 2*ch), 8'(v % 256));
    endtask

    task automatic clear_flags();
        rd_strobe(3'd2);
        rd_strobe(3'd4);
        rd_strobe(3'd6);
    endtask

    initial begin
        logic [7:0] d;
        int t;
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        for (int a = 0; a < 8; a++) begin
            peek(3'(a), d);
            chk("R1", "reset read", int'(d), 0);
        end
        chk("R1", "reset pins", int'({pin_level, pin_drive, irq}), 0);

        // R3: from reset the channel is inhibited until a lower byte write
        wr_reg(3'd0, 8'h01);
        wr_reg(3'd1, 8'h40);
        t = (m_cnt + 40) % 65536;
        wr_reg(3'd3, 8'(t / 256));
        idle(60);
        peek(3'd2, d);
        chk("R3", "no flag before low byte", int'(d[7]), 0);

        // R4: full write arms, match sets flag and pin
        prog_cmp(0, (m_cnt + 40) % 65536);
        idle(60);
        peek(3'd2, d);
        chk("R4", "flag1 on match", int'(d[7]), 1);
        chk("R4", "pin1 on match", int'(pin_level[0]), 1);

        // R9: low byte access without status read keeps flag
        rd_strobe(3'd4);
        peek(3'd2, d);
        chk("R9", "flag kept without sequence", int'(d[7]), 1);
        rd_strobe(3'd2);
        rd_strobe(3'd4);
        peek(3'd2, d);
        chk("R9", "flag cleared by sequence", int'(d[7]), 0);

        // R3: upper byte rewrite after arming disables matching
        t = (m_cnt + 40) % 65536;
        prog_cmp(0, t);
        wr_reg(3'd3, 8'(t / 256));
        idle(60);
        peek(3'd2, d);
        chk("R3", "upper rewrite inhibits", int'(d[7]), 0);

        // R5/R11: channel 2 with output disabled still flags
        wr_reg(3'd0, 8'h03);
        prog_cmp(1, (m_cnt + 40) % 65536);
        idle(60);
        peek(3'd2, d);
        chk("R5", "flag2 set", int'(d[6]), 1);
        chk("R11", "flag1 untouched", int'(d[7]), 0);
        chk("R5", "pin2 not driven", int'(pin_drive[1]), 0);
        chk("R5", "pin2 level kept", int'(pin_level[1]), 0);

        // R6: interrupt gating
        chk("R6", "irq masked", int'(irq), 0);
        wr_reg(3'd0, 8'h83);
        @(negedge clk);
        chk("R6", "irq enabled", int'(irq), 1);
        rd_strobe(3'd2);
        rd_strobe(3'd6);
        @(negedge clk);
        chk("R6", "irq after clear", int'(irq), 0);

        // R7: force copies level, no flag, no irq
        wr_reg(3'd0, 8'h80);
        wr_reg(3'd1, 8'h41);
        @(negedge clk);
        chk("R7", "forced pin1 low", int'(pin_level[0]), 0);
        chk("R7", "force no irq", int'(irq), 0);
        peek(3'd2, d);
        chk("R7", "force no flag", int'(d), 0);
        peek(3'd1, d);
        chk("R7", "force bits read 0", int'(d), 8'h40);

        // R8: force ignored in one-pulse and PWM modes
        wr_reg(3'd0, 8'h81);
        opm_active = 1'b1;
        wr_reg(3'd1, 8'h41);
        @(negedge clk);
        chk("R8", "opm blocks force", int'(pin_level[0]), 0);
        opm_active = 1'b0; pwm_active = 1'b1;
        wr_reg(3'd1, 8'h41);
        @(negedge clk);
        chk("R8", "pwm blocks force", int'(pin_level[0]), 0);
        pwm_active = 1'b0;
        wr_reg(3'd1, 8'h41);
        @(negedge clk);
        chk("R7", "force after modes", int'(pin_level[0]), 1);

        // R2: spacing of adjacent compare values at each rate
        for (int r = 0; r < 4; r++) begin
            int t1, t2;
            t1 = -1; t2 = -1;
            clear_flags();
            wr_reg(3'd1, 8'(8'hC0 | (r << 2)));
            t = (m_cnt + 24) % 65536;
            prog_cmp(0, t);
            prog_cmp(1, (t + 1) % 65536);
            @(posedge clk); #1 bus_addr = 3'd2;
            for (int k = 0; k < 600; k++) begin
                @(negedge clk);
                if (t1 < 0 && bus_rdata[7]) t1 = k;
                if (t2 < 0 && bus_rdata[6]) t2 = k;
            end
            chk("R2", "both flags seen", int'(t1 >= 0 && t2 >= 0), 1);
            chk("R2", "match spacing", t2 - t1, 1 << r);
        end

        // R2: wrap from 0xFFFF to 0 at the fastest rate
        clear_flags();
        wr_reg(3'd1, 8'h40);
        prog_cmp(0, 0);
        @(posedge clk); #1 bus_addr = 3'd2;
        for (int k = 0; k < 70000; k++) begin
            @(negedge clk);
            if (bus_rdata[7]) break;
        end
        chk("R2", "wrap match", int'(bus_rdata[7]), 1);

        idle(4);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule